// File: doc/BRIEF.md
# Protection and Auto-Restart Supervisor

This block sits between the analog comparators of an offline flyback controller and its gate driver. It takes already-digitised threshold flags (supply turn-on and turn-off, supply over-voltage, regulated-output over- and under-voltage, line brown-in and brown-out, die temperature high and recovered, current-sense low and high), the gate state, a per-switching-cycle strobe and a two-bit startup programming code. From these it produces a single switching enable, a record of the protection that shut the converter down, and the cable-drop compensation level captured at startup.

Each fault has its own qualification. Supply over-voltage, output under-voltage and brown-out are timed in ticks of an internal prescaler. Output over-voltage and brown-in are counted in switching cycles. Output under-voltage is ignored for a programmable time after each turn-on. Any qualified fault latches the converter off (auto-restart). The latch clears only when the supply collapses below the turn-off level, and switching resumes after the next turn-on. Over-temperature and the current-sense guard block switching without latching.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, `sw_en_o` is 0, `fault_o` is 0 and `cab_lvl_o` is 0.
- R2: From the off state, `vdd_on_i` moves the block to an armed state. Switching (`sw_en_o`=1) starts only after brown-in has qualified.
- R3: Brown-in qualifies after BROWN_IN_CYCLES `cyc_stb_i` strobes with `line_ok_i` high and no cycle in between with it low. A low cycle restarts the count.
- R4: Supply over-voltage (`vdd_ov_i`) trips after it has stayed high for VDD_OV_TICKS prescaler ticks, and restarts its count if it drops. The trip sets `fault_o`=1.
- R5: Output over-voltage trips after OUT_OV_CYCLES consecutive strobes with `out_ov_i` high. A low cycle restarts the count. The trip sets `fault_o`=2.
- R6: Output under-voltage is ignored for UV_MASK_TICKS ticks after turn-on. After that it trips when held for OUT_UV_TICKS ticks, setting `fault_o`=3.
- R7: Brown-out (`line_low_i` while switching) trips after BROWN_TICKS ticks and sets `fault_o`=4.
- R8: `hot_set_i` clears `sw_en_o` in the same cycle and keeps it low until `hot_clr_i`. It records no fault code.
- R9: While `gate_i` is high, `cs_high_i` clears `sw_en_o` in the same cycle. `sw_en_o` stays low until `gate_i` falls.
- R10: While the gate is on, `cs_low_i` still high once the on-time tick count reaches CS_LO_TICKS (`low_line_i`=1) or CS_HI_TICKS (`low_line_i`=0) clears `sw_en_o` until `gate_i` falls.
- R11: After a fault, `sw_en_o` stays 0 and `fault_o` holds until `vdd_off_i`. That clears `fault_o` and `cab_lvl_o`. Switching needs a new turn-on and brown-in.
- R12: `cab_lvl_o` takes `cab_code_i`+1 (1..4) at turn-on. It then ignores `cab_code_i` and returns to 0 on a fault or supply collapse.
- R13: `fault_o` keeps the first qualified fault. Conditions after the shutdown do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_on_i | input | 1 | Supply above turn-on level |
| vdd_off_i | input | 1 | Supply below turn-off level |
| vdd_ov_i | input | 1 | Supply above over-voltage level |
| out_ov_i | input | 1 | Sampled output above over-voltage level |
| out_uv_i | input | 1 | Sampled output below under-voltage level |
| line_ok_i | input | 1 | Line current above brown-in level |
| line_low_i | input | 1 | Line current below brown-out level |
| hot_set_i | input | 1 | Die temperature above the trip level |
| hot_clr_i | input | 1 | Die temperature below the recovery level |
| cs_low_i | input | 1 | Current sense below the low limit |
| cs_high_i | input | 1 | Current sense above the high limit |
| low_line_i | input | 1 | Low-line range selected |
| gate_i | input | 1 | Gate is on |
| cyc_stb_i | input | 1 | One pulse per switching cycle |
| cab_code_i | input | 2 | Startup cable-compensation code |
| sw_en_o | output | 1 | Switching enable |
| fault_o | output | 3 | First fault: 0 none, 1 supply OV, 2 output OV, 3 output UV, 4 brown-out |
| cab_lvl_o | output | 3 | Captured cable level: 0 none, 1..4 |

## Verification
The hardest case to reach is the under-voltage trip. It must occur only after the startup mask has run out, so the stimulus raises `out_uv_i` together with turn-on. It checks that no fault appears part way through the mask and that code 3 appears after mask plus debounce. The cycle-counted faults are driven with one fewer strobe than needed, then a one-cycle dropout, to show that the count restarts. A second fault condition applied after a shutdown confirms that the first code is kept.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_ARM   = 2'd1,
        S_RUN   = 2'd2,
        S_FAULT = 2'd3
    } sup_state_e;

    typedef enum logic [2:0] {
        F_NONE     = 3'd0,
        F_VDD_OV   = 3'd1,
        F_OUT_OV   = 3'd2,
        F_OUT_UV   = 3'd3,
        F_BROWNOUT = 3'd4
    } fault_e;

    localparam int unsigned NUM_QUAL = 4;

    typedef struct packed {
        logic brown;
        logic out_uv;
        logic out_ov;
        logic vdd_ov;
    } trip_t;

    function automatic fault_e first_fault(trip_t t);
        if (t.vdd_ov)      return F_VDD_OV;
        else if (t.out_ov) return F_OUT_OV;
        else if (t.out_uv) return F_OUT_UV;
        else if (t.brown)  return F_BROWNOUT;
        return F_NONE;
    endfunction

    function automatic logic [2:0] cab_level(logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/prot_tick.sv
module prot_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/prot_qual.sv
module prot_qual #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic step_i,
    output logic trip_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign trip_o = cond_i && step_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !cond_i) cnt_q <= '0;
        else if (step_i)    cnt_q <= trip_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/prot_cs_guard.sv
module prot_cs_guard #(
    parameter int unsigned LO_TICKS = 9,
    parameter int unsigned HI_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic gate_i,
    input  logic low_line_i,
    input  logic cs_low_i,
    input  logic cs_high_i,
    output logic kill_o
);
    localparam int unsigned TMAX = (LO_TICKS > HI_TICKS) ? LO_TICKS : HI_TICKS;
    localparam int unsigned W = $clog2(TMAX + 1);

    logic [W-1:0] on_q;
    logic [W-1:0] lim;
    logic         kill_now;
    logic         kill_q;

    assign lim      = low_line_i ? W'(LO_TICKS) : W'(HI_TICKS);
    assign kill_now = gate_i && (cs_high_i || ((on_q >= lim) && cs_low_i));
    assign kill_o   = kill_now || kill_q;

    always_ff @(posedge clk) begin
        if (rst || !gate_i) begin
            on_q   <= '0;
            kill_q <= 1'b0;
        end else begin
            if (tick_i && (on_q < W'(TMAX))) on_q <= on_q + 1'b1;
            kill_q <= kill_q || kill_now;
        end
    end
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import prot_pkg::*;
#(
    parameter int unsigned TICK_CYCLES     = 50,
    parameter int unsigned VDD_OV_TICKS    = 240,
    parameter int unsigned OUT_OV_CYCLES   = 4,
    parameter int unsigned OUT_UV_TICKS    = 80000,
    parameter int unsigned UV_MASK_TICKS   = 80000,
    parameter int unsigned BROWN_TICKS     = 34000,
    parameter int unsigned BROWN_IN_CYCLES = 4,
    parameter int unsigned CS_LO_TICKS     = 9,
    parameter int unsigned CS_HI_TICKS     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vdd_on_i,
    input  logic       vdd_off_i,
    input  logic       vdd_ov_i,
    input  logic       out_ov_i,
    input  logic       out_uv_i,
    input  logic       line_ok_i,
    input  logic       line_low_i,
    input  logic       hot_set_i,
    input  logic       hot_clr_i,
    input  logic       cs_low_i,
    input  logic       cs_high_i,
    input  logic       low_line_i,
    input  logic       gate_i,
    input  logic       cyc_stb_i,
    input  logic [1:0] cab_code_i,
    output logic       sw_en_o,
    output logic [2:0] fault_o,
    output logic [2:0] cab_lvl_o
);
    localparam int unsigned QLIM [NUM_QUAL] =
        '{VDD_OV_TICKS, OUT_OV_CYCLES, OUT_UV_TICKS, BROWN_TICKS};
    localparam int unsigned MW = $clog2(UV_MASK_TICKS + 1);
    localparam logic [MW-1:0] MASK_END = MW'(UV_MASK_TICKS);

    logic          tick;
    sup_state_e    st_q, st_d;
    fault_e        flt_q, flt_d;
    logic [2:0]    cab_q, cab_d;
    logic          hot_q;
    logic          active;
    logic [MW-1:0] mask_q;
    logic          mask_done;
    logic [NUM_QUAL-1:0] q_cond, q_step, q_trip;
    trip_t         trips;
    logic          bi_trip;
    logic          cs_kill;

    prot_tick #(.DIV(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    assign active    = (st_q == S_ARM) || (st_q == S_RUN);
    assign mask_done = (mask_q == MASK_END);

    // condition and time base of each latching fault, index = trip_t bit
    assign q_cond[0] = active && vdd_ov_i;
    assign q_step[0] = tick;
    assign q_cond[1] = active && out_ov_i;
    assign q_step[1] = cyc_stb_i;
    assign q_cond[2] = active && mask_done && out_uv_i;
    assign q_step[2] = tick;
    assign q_cond[3] = (st_q == S_RUN) && line_low_i;
    assign q_step[3] = tick;

    for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
        prot_qual #(.LIMIT(QLIM[g])) u_q (
            .clk(clk), .rst(rst),
            .cond_i(q_cond[g]), .step_i(q_step[g]), .trip_o(q_trip[g])
        );
    end

    assign trips = trip_t'(q_trip);

    prot_qual #(.LIMIT(BROWN_IN_CYCLES)) u_brown_in (
        .clk(clk), .rst(rst),
        .cond_i((st_q == S_ARM) && line_ok_i),
        .step_i(cyc_stb_i),
        .trip_o(bi_trip)
    );

    prot_cs_guard #(.LO_TICKS(CS_LO_TICKS), .HI_TICKS(CS_HI_TICKS)) u_cs (
        .clk(clk), .rst(rst), .tick_i(tick), .gate_i(gate_i),
        .low_line_i(low_line_i), .cs_low_i(cs_low_i), .cs_high_i(cs_high_i),
        .kill_o(cs_kill)
    );

    always_ff @(posedge clk) begin
        if (rst || st_q == S_OFF)                 mask_q <= '0;
        else if (active && tick && !mask_done)    mask_q <= mask_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            hot_q <= 1'b0;
        else if (hot_set_i) hot_q <= 1'b1;
        else if (hot_clr_i) hot_q <= 1'b0;
    end

    always_comb begin
        st_d  = st_q;
        flt_d = flt_q;
        cab_d = cab_q;
        if (vdd_off_i) begin
            st_d  = S_OFF;
            flt_d = F_NONE;
            cab_d = '0;
        end else begin
            case (st_q)
                S_OFF: if (vdd_on_i) begin
                    st_d  = S_ARM;
                    cab_d = cab_level(cab_code_i);
                end
                S_ARM, S_RUN: begin
                    if (|q_trip) begin
                        st_d  = S_FAULT;
                        flt_d = first_fault(trips);
                        cab_d = '0;
                    end else if (st_q == S_ARM && bi_trip) begin
                        st_d = S_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_OFF;
            flt_q <= F_NONE;
            cab_q <= '0;
        end else begin
            st_q  <= st_d;
            flt_q <= flt_d;
            cab_q <= cab_d;
        end
    end

    assign sw_en_o   = (st_q == S_RUN) && !hot_set_i && !hot_q && !cs_kill;
    assign fault_o   = flt_q;
    assign cab_lvl_o = cab_q;
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       vdd_off_i,
    input logic       hot_set_i,
    input logic       gate_i,
    input logic       cs_high_i,
    input logic       sw_en_o,
    input logic [2:0] fault_o,
    input logic [2:0] cab_lvl_o
);
    a_r11_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 3'd0) |-> !sw_en_o);

    a_r13_fault_held: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 3'd0 && !vdd_off_i) |=> (fault_o == $past(fault_o)));

    a_r11_collapse_clears: assert property (@(posedge clk) disable iff (rst)
        vdd_off_i |=> (fault_o == 3'd0 && cab_lvl_o == 3'd0 && !sw_en_o));

    a_r8_hot_blocks: assert property (@(posedge clk) disable iff (rst)
        hot_set_i |-> !sw_en_o);

    a_r9_cs_high_blocks: assert property (@(posedge clk) disable iff (rst)
        (gate_i && cs_high_i) |-> !sw_en_o);

    a_r12_fault_drops_cable: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 3'd0) |-> (cab_lvl_o == 3'd0));

    a_r12_cable_held: assert property (@(posedge clk) disable iff (rst)
        (cab_lvl_o != 3'd0) |=> (cab_lvl_o == $past(cab_lvl_o) || cab_lvl_o == 3'd0));

    a_r2_run_has_cable: assert property (@(posedge clk) disable iff (rst)
        sw_en_o |-> (cab_lvl_o != 3'd0));
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .vdd_off_i(vdd_off_i), .hot_set_i(hot_set_i),
    .gate_i(gate_i), .cs_high_i(cs_high_i), .sw_en_o(sw_en_o),
    .fault_o(fault_o), .cab_lvl_o(cab_lvl_o)
);

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;
    localparam int TC    = 4;
    localparam int OVT   = 6;
    localparam int OVC   = 4;
    localparam int UVT   = 10;
    localparam int MASKT = 20;
    localparam int BOT   = 8;
    localparam int BIC   = 4;
    localparam int LOT   = 5;
    localparam int HIT   = 2;
    localparam int TMAX  = (LOT > HIT) ? LOT : HIT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vdd_on = 0, vdd_off = 0, vdd_ov = 0, out_ov = 0, out_uv = 0;
    logic line_ok = 0, line_low = 0, hot_set = 0, hot_clr = 0;
    logic cs_low = 0, cs_high = 0, low_line = 0, gate = 0, stb = 0;
    logic [1:0] code = 2'd0;
    logic sw_en;
    logic [2:0] fault, cab;

    always #4 clk = ~clk;

    prot_supervisor #(
        .TICK_CYCLES(TC), .VDD_OV_TICKS(OVT), .OUT_OV_CYCLES(OVC),
        .OUT_UV_TICKS(UVT), .UV_MASK_TICKS(MASKT), .BROWN_TICKS(BOT),
        .BROWN_IN_CYCLES(BIC), .CS_LO_TICKS(LOT), .CS_HI_TICKS(HIT)
    ) u0 (
        .clk(clk), .rst(rst), .vdd_on_i(vdd_on), .vdd_off_i(vdd_off),
        .vdd_ov_i(vdd_ov), .out_ov_i(out_ov), .out_uv_i(out_uv),
        .line_ok_i(line_ok), .line_low_i(line_low), .hot_set_i(hot_set),
        .hot_clr_i(hot_clr), .cs_low_i(cs_low), .cs_high_i(cs_high),
        .low_line_i(low_line), .gate_i(gate), .cyc_stb_i(stb),
        .cab_code_i(code), .sw_en_o(sw_en), .fault_o(fault), .cab_lvl_o(cab)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: st 0 off, 1 armed, 2 running, 3 faulted
    int m_p, m_st, m_flt, m_cab, m_m, m_t, m_bi;
    int m_c [4];
    bit m_kq, m_hot;
    int lims [4] = '{OVT, OVC, UVT, BOT};

    function automatic int cs_lim();
        return low_line ? LOT : HIT;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_p = 0; m_st = 0; m_flt = 0; m_cab = 0; m_m = 0; m_t = 0;
            m_bi = 0; m_kq = 0; m_hot = 0;
            foreach (m_c[i]) m_c[i] = 0;
        end else begin
            bit tk, act, run, mdone, bi_ok, kn, any;
            bit cond [4];
            bit stp [4];
            bit trp [4];
            int first;
            tk = (m_p == TC - 1);
            act = (m_st == 1 || m_st == 2);
            run = (m_st == 2);
            mdone = (m_m == MASKT);
            cond[0] = act && vdd_ov;            stp[0] = tk;
            cond[1] = act && out_ov;            stp[1] = stb;
            cond[2] = act && mdone && out_uv;   stp[2] = tk;
            cond[3] = run && line_low;          stp[3] = tk;
            any = 0; first = 0;
            for (int i = 0; i < 4; i++) begin
                trp[i] = cond[i] && stp[i] && (m_c[i] == lims[i] - 1);
                if (!cond[i]) m_c[i] = 0;
                else if (stp[i]) m_c[i] = trp[i] ? 0 : m_c[i] + 1;
                if (trp[i] && !any) begin any = 1; first = i + 1; end
            end
            bi_ok = (m_st == 1) && line_ok && stb && (m_bi == BIC - 1);
            if (!(m_st == 1 && line_ok)) m_bi = 0;
            else if (stb) m_bi = bi_ok ? 0 : m_bi + 1;
            kn = gate && (cs_high || (m_t >= cs_lim() && cs_low));
            m_kq = gate && (m_kq || kn);
            if (!gate) m_t = 0;
            else if (tk && m_t < TMAX) m_t++;
            if (hot_set) m_hot = 1; else if (hot_clr) m_hot = 0;
            if (m_st == 0) m_m = 0;
            else if (act && tk && !mdone) m_m++;
            if (vdd_off) begin
                m_st = 0; m_flt = 0; m_cab = 0;
            end else if (m_st == 0) begin
                if (vdd_on) begin m_st = 1; m_cab = code + 1; end
            end else if (act) begin
                if (any) begin m_st = 3; m_flt = first; m_cab = 0; end
                else if (m_st == 1 && bi_ok) m_st = 2;
            end
            m_p = tk ? 0 : m_p + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int exp_sw;
            exp_sw = (m_st == 2 && !hot_set && !m_hot && !m_kq &&
                      !(gate && (cs_high || (m_t >= cs_lim() && cs_low)))) ? 1 : 0;
            chk({cur_req, " model sw_en"}, int'(sw_en), exp_sw);
            chk({cur_req, " model fault"}, int'(fault), m_flt);
            chk({cur_req, " model cable"}, int'(cab), m_cab);
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(int n);
        repeat (n) begin
            stb = 1; cyc(1);
            stb = 0; cyc(1);
        end
    endtask

    task automatic power_up(logic [1:0] c);
        code = c; vdd_on = 1; cyc(2);
        line_ok = 1; strobe(BIC); cyc(1);
    endtask

    task automatic collapse();
        vdd_on = 0; line_ok = 0; vdd_off = 1; cyc(2);
        vdd_off = 0; cyc(1);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        #3;
        cur_req = "R1";
        chk("R1 reset sw_en", int'(sw_en), 0);
        chk("R1 reset fault", int'(fault), 0);
        chk("R1 reset cable", int'(cab), 0);
        cyc(2);

        // R3: interrupted brown-in, then R2 switching starts
        cur_req = "R3";
        code = 2'd2; vdd_on = 1; cyc(2);
        line_ok = 1; strobe(BIC - 1);
        line_ok = 0; cyc(1); line_ok = 1;
        strobe(BIC - 1);
        chk("R3 count restarted", int'(sw_en), 0);
        strobe(1); cyc(1);
        cur_req = "R2";
        chk("R2 switching after brown-in", int'(sw_en), 1);
        cur_req = "R12";
        chk("R12 cable captured", int'(cab), 3);
        code = 2'd0; cyc(3);
        chk("R12 code ignored after capture", int'(cab), 3);

        // R9: over-current during on-time
        cur_req = "R9";
        gate = 1; cs_high = 1; #1;
        chk("R9 immediate kill", int'(sw_en), 0);
        cyc(1); cs_high = 0; cyc(2);
        chk("R9 kill held until gate falls", int'(sw_en), 0);
        gate = 0; cyc(1);
        chk("R9 released after gate off", int'(sw_en), 1);

        // R10: current sense stuck low, both line ranges
        cur_req = "R10";
        low_line = 1; cs_low = 1; gate = 1; cyc(2);
        chk("R10 low line before limit", int'(sw_en), 1);
        cyc((LOT + 1) * TC);
        chk("R10 low line after limit", int'(sw_en), 0);
        gate = 0; cyc(2);
        low_line = 0; gate = 1; cyc(2);
        chk("R10 high line before limit", int'(sw_en), 1);
        cyc((HIT + 1) * TC);
        chk("R10 high line after limit", int'(sw_en), 0);
        gate = 0; cs_low = 0; cyc(2);

        // R8: over-temperature hysteresis
        cur_req = "R8";
        hot_set = 1; #1;
        chk("R8 immediate stop", int'(sw_en), 0);
        cyc(1); hot_set = 0; cyc(4);
        chk("R8 held until clear", int'(sw_en), 0);
        chk("R8 no fault code", int'(fault), 0);
        hot_clr = 1; cyc(1); hot_clr = 0; cyc(1);
        chk("R8 resumes", int'(sw_en), 1);

        // R4: supply over-voltage, short pulse then qualified
        cur_req = "R4";
        vdd_ov = 1; cyc(2 * TC); vdd_ov = 0; cyc(1);
        chk("R4 short pulse ignored", int'(fault), 0);
        vdd_ov = 1; cyc((OVT + 1) * TC + 2); vdd_ov = 0; cyc(3);
        chk("R4 fault code", int'(fault), 1);
        chk("R4 switching off", int'(sw_en), 0);
        cur_req = "R11";
        cyc(10);
        chk("R11 fault latched", int'(fault), 1);
        collapse();
        chk("R11 fault cleared", int'(fault), 0);
        chk("R11 cable cleared", int'(cab), 0);
        chk("R11 no switching before turn-on", int'(sw_en), 0);

        // R5: output over-voltage by cycle count
        cur_req = "R5";
        power_up(2'd1);
        out_ov = 1; strobe(OVC - 1);
        out_ov = 0; cyc(1); out_ov = 1;
        strobe(OVC - 1);
        chk("R5 count restarted", int'(fault), 0);
        strobe(1); out_ov = 0; cyc(1);
        chk("R5 fault code", int'(fault), 2);
        cur_req = "R13";
        vdd_ov = 1; line_low = 1; cyc((OVT + 2) * TC);
        chk("R13 first fault kept", int'(fault), 2);
        vdd_ov = 0; line_low = 0;
        collapse();

        // R6: under-voltage masked at startup
        cur_req = "R6";
        out_uv = 1;
        power_up(2'd3);
        cyc(MASKT * TC / 2);
        chk("R6 masked early", int'(fault), 0);
        cyc((MASKT + UVT + 2) * TC);
        chk("R6 fault code", int'(fault), 3);
        out_uv = 0;
        collapse();

        // R7: brown-out while switching
        cur_req = "R7";
        power_up(2'd0);
        chk("R7 running", int'(sw_en), 1);
        line_low = 1; cyc((BOT + 2) * TC);
        chk("R7 fault code", int'(fault), 4);
        line_low = 0;
        collapse();
        cur_req = "R11";
        power_up(2'd3);
        chk("R11 restart switches", int'(sw_en), 1);
        chk("R12 recaptured", int'(cab), 4);
        cyc(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule